// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Per-Processor Masking

This block gathers fifteen active-high request lines, numbered 1 to 15, and gives each of a parameterized number of processors a 4-bit code. The code names the most urgent interrupt that processor should take. A 32-bit register port reads and writes the configuration and state. That state holds one shared pending word, a word that puts each interrupt in a high or a low priority group, a word that routes an interrupt to every processor instead of the shared pending word, and a mask and a force word for each processor. Software clears pending interrupts through a write-one-to-clear register. A processor clears an interrupt by pulsing its acknowledge input with the interrupt number.

Each processor works from its own candidate set: the pending word OR its force word, ANDed with its mask. If any candidate is in the high group, the block offers the high group. Otherwise it offers the low group. Within the offered group the highest-numbered set bit wins. That number is registered and appears on the processor's 4-bit output one clock after the state changes. A code of 0 means that no interrupt is requested.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and every processor output is 0.
- R2: Interrupt 0 does not exist. Bit 0 reads back as zero in the group, broadcast, mask and force registers after any write, and a rise on request line 0 sets nothing. The mask register keeps bits 15:1 only.
- R3: A processor's candidates are (pending OR own force) AND own mask. When any candidate has its group bit (group register at offset 0x00) set to 1, only those candidates are considered. Otherwise all candidates are considered.
- R4: A write to a processor's force register (offset 0x80+4n) sets the bits in value[15:1] and then clears the bits in value[31:17], where bit 16+k clears bit k. A write to offset 0x08 overwrites processor 0's force register with value[15:1].
- R5: A write to offset 0x0C clears the pending bits written as 1.
- R6: The pending register (offset 0x04) cannot be changed by a bus write. Writes to it and to the status offset 0x10 have no effect.
- R7: A rising request k with bit k set in the broadcast register (offset 0x14) sets bit k in every processor's force register and leaves pending unchanged. With that bit clear, the rise sets pending bit k.
- R8: An acknowledge from processor n with number k clears pending bit k and bit k of processor n's force register. A new rise of k in the same cycle wins, so the bit stays set.
- R9: Requests are edge-captured. A line held high sets its bit once, and a bit cleared while the line stays high remains clear.
- R10: The extended register of processor n (offset 0xC0+4n) stores value[3:0] and reads back that value. It has no effect on any output.
- R11: The clear and status offsets, unmapped offsets, and per-processor offsets beyond the processor count read as zero. Only address bits 7:0 are decoded.
- R12: The output is the number of the highest set bit of the selected group. It is registered, so it changes one clock after the state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request lines; bit k is interrupt k, bit 0 unused |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per 32-bit write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Per-processor acknowledged interrupt number, field n at [4n+3:4n] |
| cpu_lvl | output | 4*NCPU | Per-processor interrupt code, field n at [4n+3:4n] |

## Verification
The assertions assume that reset is held low for at least one clock, that bus strobes are single-cycle 32-bit accesses with a word-aligned address, and that the request lines are synchronous to the clock. The bench drives every input at the falling edge and holds a strobe for exactly one cycle. It raises request lines only from a low state, except in the test that holds a line high on purpose. It never issues a read and a write in the same cycle. Acknowledges carry a 4-bit number, so modulo-16 wrapping is given by the port width.

// File: rtl/irqc_pkg.sv
// Package: shared constants and helpers for the prioritized interrupt
// controller. Assumes 16 interrupt bit positions, position 0 unused.
package irqc_pkg;
    localparam int IRQ_W   = 16;
    localparam int CODE_W  = 4;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 8;
    localparam logic [IRQ_W-1:0] KEEP_MASK = 16'hFFFE;

    localparam logic [ADDR_W-1:0] A_GROUP  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h04;
    localparam logic [ADDR_W-1:0] A_FALIAS = 8'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h10;
    localparam logic [ADDR_W-1:0] A_BCAST  = 8'h14;
    localparam logic [1:0] BANK_MASK  = 2'b01;
    localparam logic [1:0] BANK_FORCE = 2'b10;
    localparam logic [1:0] BANK_EXT   = 2'b11;

    // Number of the highest set bit at positions 15..1, or 0 when none is set.
    function automatic logic [CODE_W-1:0] top_bit(input logic [IRQ_W-1:0] v);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = 1; i < IRQ_W; i++) begin
            if (v[i]) r = CODE_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_edge.sv
// Module: rising-edge capture of the request lines.
// Assumes lines are synchronous to clk. Position 0 never reports a rise.
module irqc_edge
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] lines,
    output logic [IRQ_W-1:0] rise
);
    logic [IRQ_W-1:0] prev_q;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    // A rise is a line high now and low last cycle; position 0 is dropped.
    always_comb rise = lines & ~prev_q & KEEP_MASK;

    // R9: a rise is never reported on two cycles in a row.
    p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & $past(rise)) == '0);
endmodule

// File: rtl/irqc_prio.sv
// Module: per-processor selection. Builds the candidate set, picks the
// high group if it is non-empty, otherwise the low group, and registers the
// number of the highest set bit. Assumes inputs are register outputs.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  pend,
    input  logic [IRQ_W-1:0]  frc,
    input  logic [IRQ_W-1:0]  msk,
    input  logic [IRQ_W-1:0]  grp,
    output logic [CODE_W-1:0] lvl_o
);
    logic [IRQ_W-1:0] cand;
    logic [IRQ_W-1:0] hi_set;
    logic [IRQ_W-1:0] lo_set;
    logic [IRQ_W-1:0] pick;

    // Candidate sets for the two groups and the chosen one.
    always_comb begin
        cand   = (pend | frc) & msk;
        hi_set = cand & grp;
        lo_set = cand & ~grp;
        pick   = (hi_set != '0) ? hi_set : lo_set;
    end

    // Register the encoded winner.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_o <= '0;
        else        lvl_o <= top_bit(pick);
    end

    // R3: a non-zero code names a bit that was a candidate.
    p_code_is_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != '0) |-> (($past(cand) & (16'h1 << lvl_o)) != '0));
    // R3: when high-group candidates existed, the code is one of them.
    p_high_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cand & grp) != '0) |-> (($past(grp) & (16'h1 << lvl_o)) != '0));
    // R12: no candidates gives code 0 one cycle later.
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cand) == '0) |-> (lvl_o == '0));
endmodule

// File: rtl/irqc_rdmux.sv
// Module: read-data selection for the register port. Combinational; returns
// zero when the read strobe is low or the offset is not mapped.
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [IRQ_W-1:0]           grp,
    input  logic [IRQ_W-1:0]           pend,
    input  logic [IRQ_W-1:0]           bcast,
    input  logic [NCPU-1:0][IRQ_W-1:0] msk,
    input  logic [NCPU-1:0][IRQ_W-1:0] frc,
    input  logic [NCPU-1:0][3:0]       ext,
    output logic [BUS_W-1:0]           rdata
);
    logic [3:0] idx;
    logic       idx_ok;

    // Pick the addressed register value.
    always_comb begin
        idx    = addr[5:2];
        idx_ok = (int'(idx) < NCPU) && (addr[1:0] == 2'b00);
        rdata  = '0;
        if (rd) begin
            if (addr == A_GROUP)       rdata = {16'h0, grp};
            else if (addr == A_PEND)   rdata = {16'h0, pend};
            else if (addr == A_FALIAS) rdata = {16'h0, frc[0]};
            else if (addr == A_BCAST)  rdata = {16'h0, bcast};
            else if (idx_ok && addr[7:6] == BANK_MASK)  rdata = {16'h0, msk[idx]};
            else if (idx_ok && addr[7:6] == BANK_FORCE) rdata = {16'h0, frc[idx]};
            else if (idx_ok && addr[7:6] == BANK_EXT)   rdata = {28'h0, ext[idx]};
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt controller. Holds the group,
// pending, broadcast, mask, force and extended registers, applies bus writes,
// request rises and acknowledges, and feeds one selector per processor.
// Assumes single-cycle 32-bit accesses and NCPU no larger than 16.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IRQ_W-1:0]       irq_in,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic [NCPU-1:0]        ack_vld,
    input  logic [NCPU*CODE_W-1:0] ack_num,
    output logic [NCPU*CODE_W-1:0] cpu_lvl
);
    localparam int IDX_W = 4;

    logic [IRQ_W-1:0]           grp_q, pend_q, bcast_q;
    logic [NCPU-1:0][IRQ_W-1:0] msk_q, frc_q, frc_d;
    logic [NCPU-1:0][3:0]       ext_q;
    logic [NCPU-1:0][IRQ_W-1:0] ack_oh;
    logic [IRQ_W-1:0]           ack_all, rise, pend_d;
    logic [IRQ_W-1:0]           set_bits, clr_bits;
    logic                       w_grp, w_alias, w_clear, w_bcast;
    logic [NCPU-1:0]            w_msk, w_frc, w_ext;

    irqc_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise)
    );

    // Decode global write strobes.
    always_comb begin
        w_grp    = bus_wr && (bus_addr == A_GROUP);
        w_alias  = bus_wr && (bus_addr == A_FALIAS);
        w_clear  = bus_wr && (bus_addr == A_CLEAR);
        w_bcast  = bus_wr && (bus_addr == A_BCAST);
        set_bits = bus_wdata[15:0] & KEEP_MASK;
        clr_bits = bus_wdata[31:16] & KEEP_MASK;
    end

    // Decode per-processor write strobes.
    for (genvar n = 0; n < NCPU; n++) begin : g_dec
        logic hit;
        always_comb begin
            hit      = bus_wr && (bus_addr[5:2] == IDX_W'(n)) && (bus_addr[1:0] == 2'b00);
            w_msk[n] = hit && (bus_addr[7:6] == BANK_MASK);
            w_frc[n] = hit && (bus_addr[7:6] == BANK_FORCE);
            w_ext[n] = hit && (bus_addr[7:6] == BANK_EXT);
        end
    end

    // Turn acknowledges into one-hot clear masks.
    always_comb begin
        ack_all = '0;
        for (int n = 0; n < NCPU; n++) begin
            ack_oh[n] = ack_vld[n] ? (16'h1 << ack_num[n*CODE_W +: CODE_W]) : '0;
            ack_all   = ack_all | ack_oh[n];
        end
    end

    // Next pending and force values; new rises win over clears.
    always_comb begin
        pend_d = pend_q;
        if (w_clear) pend_d = pend_d & ~set_bits;
        pend_d = (pend_d & ~ack_all) | (rise & ~bcast_q);
        for (int n = 0; n < NCPU; n++) begin
            frc_d[n] = frc_q[n];
            if (n == 0 && w_alias) frc_d[n] = set_bits;
            else if (w_frc[n])     frc_d[n] = (frc_q[n] | set_bits) & ~clr_bits;
            frc_d[n] = (frc_d[n] & ~ack_oh[n] & KEEP_MASK) | (rise & bcast_q);
        end
    end

    // Global register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            pend_q  <= '0;
            bcast_q <= '0;
        end else begin
            if (w_grp)   grp_q   <= set_bits;
            if (w_bcast) bcast_q <= set_bits;
            pend_q <= pend_d;
        end
    end

    // Per-processor register state and selectors.
    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msk_q[n] <= '0;
                frc_q[n] <= '0;
                ext_q[n] <= '0;
            end else begin
                if (w_msk[n]) msk_q[n] <= set_bits;
                if (w_ext[n]) ext_q[n] <= bus_wdata[3:0];
                frc_q[n] <= frc_d[n];
            end
        end

        irqc_prio u_prio (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend_q),
            .frc   (frc_q[n]),
            .msk   (msk_q[n]),
            .grp   (grp_q),
            .lvl_o (cpu_lvl[n*CODE_W +: CODE_W])
        );

        // R7: a broadcast rise lands in this processor's force register.
        p_bcast_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rise & bcast_q) & ~frc_q[n]) == '0);
    end

    irqc_rdmux #(.NCPU(NCPU)) u_rd (
        .rd    (bus_rd),
        .addr  (bus_addr),
        .grp   (grp_q),
        .pend  (pend_q),
        .bcast (bcast_q),
        .msk   (msk_q),
        .frc   (frc_q),
        .ext   (ext_q),
        .rdata (bus_rdata)
    );

    // R6: pending only gains bits from non-broadcast rises.
    p_pend_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(rise & ~bcast_q)) == '0);
    // R8: an acknowledged bit is clear next cycle unless it rose again.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & $past(ack_all & ~rise)) == '0);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam int NCPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCPU-1:0]   ack_vld = '0;
    logic [NCPU*4-1:0] ack_num = '0;
    logic [NCPU*4-1:0] cpu_lvl;

    typedef struct {
        bit          is_lvl;
        int          cpu;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NCPU(NCPU)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack_vld(ack_vld), .ack_num(ack_num),
        .cpu_lvl(cpu_lvl)
    );

    // Monitor: pops one expected item per cycle, shortly after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                got = it.is_lvl ? {28'h0, cpu_lvl[it.cpu*4 +: 4]} : bus_rdata;
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.is_lvl = 1'b0; it.cpu = 0; it.exp = e; it.req = r;
        q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic lvl(input int c, input logic [3:0] e, input string r);
        item_t it;
        @(negedge clk);
        it.is_lvl = 1'b1; it.cpu = c; it.exp = {28'h0, e}; it.req = r;
        q.push_back(it);
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        irq_in[k] = 1'b1;
        @(negedge clk);
        irq_in[k] = 1'b0;
    endtask

    task automatic ack(input int c, input logic [3:0] k);
        @(negedge clk);
        ack_vld[c] = 1'b1; ack_num[c*4 +: 4] = k;
        @(negedge clk);
        ack_vld[c] = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(8'h00, 32'h0, "R1 group");
        rd(8'h04, 32'h0, "R1 pending");
        rd(8'h14, 32'h0, "R1 broadcast");
        rd(8'h40, 32'h0, "R1 mask0");
        lvl(0, 4'd0, "R1 cpu0 code");
        // R2: bit 0 dropped on writes, upper mask bits dropped
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0000_FFFE, "R2 mask0 readback");
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, 32'h0, "R2 broadcast bit0");
        pulse(0);
        rd(8'h04, 32'h0, "R2 line 0 ignored");
        // R7/R12: plain rise goes to pending, code follows
        pulse(5);
        rd(8'h04, 32'h0000_0020, "R7 pending from rise");
        lvl(0, 4'd5, "R12 cpu0 code 5");
        lvl(1, 4'd0, "R3 cpu1 masked off");
        pulse(3);
        lvl(0, 4'd5, "R12 highest bit wins");
        // R3: group register pulls 3 ahead of 5
        wr(8'h00, 32'h0000_0008);
        lvl(0, 4'd3, "R3 high group first");
        // R8: acknowledge clears pending bit
        ack(0, 4'd3);
        rd(8'h04, 32'h0000_0020, "R8 ack cleared bit 3");
        lvl(0, 4'd5, "R8 code after ack");
        // R5: write-one-to-clear
        wr(8'h0C, 32'h0000_0021);
        rd(8'h04, 32'h0, "R5 pending cleared");
        lvl(0, 4'd0, "R5 code idle");
        // R11: clear and status read zero
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R11 clear reads zero");
        rd(8'h10, 32'h0, "R11 status reads zero");
        // R6: pending not writable
        wr(8'h04, 32'h0000_0004);
        rd(8'h04, 32'h0, "R6 pending write ignored");
        lvl(0, 4'd0, "R6 code unchanged");
        // R4: set then clear halves of force register
        wr(8'h84, 32'h0006_0C06);
        rd(8'h84, 32'h0000_0C00, "R4 force set/clear");
        wr(8'h84, 32'h0800_0000);
        rd(8'h84, 32'h0000_0400, "R4 force clear half");
        wr(8'h08, 32'h0000_00F1);
        rd(8'h80, 32'h0000_00F0, "R4 alias overwrite");
        lvl(0, 4'd7, "R4 forced code");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h0, "R4 alias cleared");
        // R7: broadcast goes to every force register
        wr(8'h14, 32'h0000_0080);
        pulse(7);
        rd(8'h04, 32'h0, "R7 broadcast skips pending");
        rd(8'h80, 32'h0000_0080, "R7 force0 set");
        rd(8'h84, 32'h0000_0480, "R7 force1 set");
        wr(8'h44, 32'h0000_0080);
        lvl(1, 4'd7, "R7 cpu1 code");
        lvl(0, 4'd7, "R7 cpu0 code");
        // R8: acknowledge from cpu1 touches only its own force
        ack(1, 4'd7);
        rd(8'h84, 32'h0000_0400, "R8 force1 acked");
        rd(8'h80, 32'h0000_0080, "R8 force0 kept");
        lvl(1, 4'd0, "R8 cpu1 code idle");
        // R9: held line sets once
        @(negedge clk);
        irq_in[9] = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h04, 32'h0000_0200, "R9 held line sets");
        wr(8'h0C, 32'h0000_0200);
        repeat (2) @(negedge clk);
        rd(8'h04, 32'h0, "R9 held line no re-set");
        @(negedge clk);
        irq_in[9] = 1'b0;
        // R8: same-cycle ack and rise, rise wins
        @(negedge clk);
        irq_in[9] = 1'b1; ack_vld[0] = 1'b1; ack_num[3:0] = 4'd9;
        @(negedge clk);
        irq_in[9] = 1'b0; ack_vld[0] = 1'b0;
        rd(8'h04, 32'h0000_0200, "R8 rise wins over ack");
        lvl(0, 4'd9, "R8 cpu0 code 9");
        // R10: extended register stores 4 bits, no effect
        wr(8'hC4, 32'hFFFF_FFFF);
        rd(8'hC4, 32'h0000_000F, "R10 extended readback");
        lvl(0, 4'd9, "R10 cpu0 unaffected");
        lvl(1, 4'd0, "R10 cpu1 unaffected");
        // R11: unmapped and out-of-range offsets
        rd(8'hC8, 32'h0, "R11 beyond processors");
        rd(8'h20, 32'h0, "R11 unmapped");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule